// File: doc/BRIEF.md
# LIN bus error monitor

This block sits next to a LIN transmitter and receiver and watches the bus for three kinds of fault. The first is a bus held dominant (low) for too long while a frame is in progress. The second is a transmitted byte whose readback from the bus differs from what was sent. The third is a byte that arrives when no frame is running and that the receiver did not recognise as a wake-up or break character.

Each fault sets a sticky flag that software clears by writing a one to its bit. An unrequested byte also raises a receive-ready flag and a `blocked` indication. `blocked` tells the surrounding logic to stop normal operation, and it drops only when the receive data register is read. A single interrupt line combines the flags, each through its own enable.

The dominant-bus detector counts only cycles that carry the sample-clock enable. It needs 31 consecutive low samples. Any high sample restarts it, and it saturates so that one long low period raises the flag once.

Top module: `lin_err_monitor`

## Requirements
- R1: After reset, `pberr`, `berr`, `rxrdy`, `blocked` and `irq` are all 0.
- R2: While `frame_act` is 1, the 31st consecutive low sample of `rx_line` sets `pberr` on that clock edge. A sample is a cycle with `smp_en` = 1; cycles without `smp_en` are neither counted nor restart the count.
- R3: A high sample of `rx_line` restarts the low-sample count, so 30 low samples, one high sample and 30 more low samples leave `pberr` at 0.
- R4: Low samples taken while `frame_act` is 0 are not counted, and `frame_act` = 0 restarts the count.
- R5: The count saturates. Once `pberr` is set and then cleared, further low samples do not set it again until a high sample has been seen.
- R6: A `tx_done` strobe with `fast_chk` = 0 sets `berr` when `tx_byte` differs from `rx_byte`, and leaves it alone when they match.
- R7: With `fast_chk` = 1, a `tx_done` strobe with differing bytes does not set `berr`.
- R8: An `rx_valid` strobe with `frame_act` = 0 and `wake_brk` = 0 sets `berr`, `rxrdy` and `blocked`. With `frame_act` = 1 or `wake_brk` = 1, the strobe changes none of them.
- R9: `blocked` is cleared only by `dreg_rd`; a flag-clear write does not affect it.
- R10: A cycle with `clr_wr` = 1 clears each flag whose bit in `clr_data` is 1: bit 0 clears `pberr`, bit 1 clears `berr`, bit 2 clears `rxrdy`. Flags whose bit is 0 keep their value. A set and a clear of the same flag in one cycle leave the flag at 1.
- R11: `irq` is 1 exactly when some flag is 1 and its bit in `irq_en` is 1, using the same bit order as `clr_data`. `irq` follows the registered flags without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Sample-clock enable for `rx_line` |
| rx_line | input | 1 | Sampled receive line (0 = dominant) |
| frame_act | input | 1 | A frame is being transmitted or received |
| tx_done | input | 1 | Strobe: a byte field has been sent and read back |
| tx_byte | input | 8 | Byte that was transmitted |
| rx_byte | input | 8 | Byte received from the bus |
| rx_valid | input | 1 | Strobe: receiver has completed a byte |
| wake_brk | input | 1 | Received byte is a recognised wake-up or break |
| fast_chk | input | 1 | 1 = fast bit checking in use; disables byte readback check |
| dreg_rd | input | 1 | Strobe: receive data register was read |
| clr_wr | input | 1 | Flag-clear write strobe |
| clr_data | input | 3 | Write-one-to-clear mask {rxrdy, berr, pberr} |
| irq_en | input | 3 | Interrupt enables {rxrdy, berr, pberr} |
| pberr | output | 1 | Sticky stuck-dominant bus flag |
| berr | output | 1 | Sticky bit-error / unrequested-byte flag |
| rxrdy | output | 1 | Sticky receive-ready flag from an unrequested byte |
| blocked | output | 1 | Normal operation held until data register read |
| irq | output | 1 | Combined, enabled interrupt |

## Verification
The properties assume that the strobes `tx_done`, `rx_valid`, `dreg_rd` and `clr_wr` are single-cycle pulses. They also assume that `tx_byte` and `rx_byte` are valid in the cycle of the strobe that uses them. The bench drives every input on the falling edge and deasserts each strobe after exactly one cycle. It changes `frame_act`, `fast_chk` and `wake_brk` only while no strobe is pending, so every flag rise has a single cause in the previous cycle.

// File: rtl/lin_mon_pkg.sv
package lin_mon_pkg;
    localparam int NFLAG  = 3;
    localparam int IDX_PB = 0;
    localparam int IDX_BE = 1;
    localparam int IDX_RR = 2;

    typedef struct packed {
        logic blocked;
    } top_state_t;
endpackage

// File: rtl/lin_dom_detect.sv
module lin_dom_detect #(
    parameter int THRESH = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic rx_line,
    input  logic frame_act,
    output logic hit
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIM    = CW'(THRESH);
    localparam logic [CW-1:0] LIM_M1 = CW'(THRESH - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dom_state_t;

    dom_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (!frame_act) begin
            st_d.cnt = '0;
        end else if (smp_en) begin
            if (rx_line) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != LIM) begin
                st_d.cnt = st_q.cnt + CW'(1);
                if (st_q.cnt == LIM_M1) begin
                    hit = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lin_byte_check.sv
module lin_byte_check #(
    parameter int DW = 8
) (
    input  logic          tx_done,
    input  logic          fast_chk,
    input  logic [DW-1:0] tx_byte,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_valid,
    input  logic          frame_act,
    input  logic          wake_brk,
    output logic          mismatch_hit,
    output logic          unreq_hit
);
    logic [DW-1:0] diff;

    always_comb begin
        diff         = tx_byte ^ rx_byte;
        mismatch_hit = tx_done && !fast_chk && (|diff);
        unreq_hit    = rx_valid && !frame_act && !wake_brk;
    end
endmodule

// File: rtl/lin_flag_bank.sv
module lin_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] flags_q
);
    logic [N-1:0] flags_d;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flags_d[i] = set[i] | (flags_q[i] & ~(clr_wr & clr_data[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end
endmodule

// File: rtl/lin_err_monitor.sv
module lin_err_monitor
    import lin_mon_pkg::*;
#(
    parameter int DW     = 8,
    parameter int THRESH = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic          rx_line,
    input  logic          frame_act,
    input  logic          tx_done,
    input  logic [DW-1:0] tx_byte,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_valid,
    input  logic          wake_brk,
    input  logic          fast_chk,
    input  logic          dreg_rd,
    input  logic          clr_wr,
    input  logic [2:0]    clr_data,
    input  logic [2:0]    irq_en,
    output logic          pberr,
    output logic          berr,
    output logic          rxrdy,
    output logic          blocked,
    output logic          irq
);
    logic             dom_hit;
    logic             mis_hit;
    logic             unreq_hit;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags;
    top_state_t       st_d, st_q;

    lin_dom_detect #(.THRESH(THRESH)) u_dom (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (smp_en),
        .rx_line   (rx_line),
        .frame_act (frame_act),
        .hit       (dom_hit)
    );

    lin_byte_check #(.DW(DW)) u_chk_byte (
        .tx_done      (tx_done),
        .fast_chk     (fast_chk),
        .tx_byte      (tx_byte),
        .rx_byte      (rx_byte),
        .rx_valid     (rx_valid),
        .frame_act    (frame_act),
        .wake_brk     (wake_brk),
        .mismatch_hit (mis_hit),
        .unreq_hit    (unreq_hit)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[IDX_PB] = dom_hit;
        set_vec[IDX_BE] = mis_hit | unreq_hit;
        set_vec[IDX_RR] = unreq_hit;
    end

    lin_flag_bank #(.N(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (set_vec),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .flags_q  (flags)
    );

    always_comb begin
        st_d = st_q;
        if (unreq_hit) begin
            st_d.blocked = 1'b1;
        end else if (dreg_rd) begin
            st_d.blocked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pberr   = flags[IDX_PB];
    assign berr    = flags[IDX_BE];
    assign rxrdy   = flags[IDX_RR];
    assign blocked = st_q.blocked;
    assign irq     = |(flags & irq_en);
endmodule

// File: rtl/lin_err_monitor_chk.sv
module lin_err_monitor_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_en,
    input logic          rx_line,
    input logic          frame_act,
    input logic          tx_done,
    input logic [DW-1:0] tx_byte,
    input logic [DW-1:0] rx_byte,
    input logic          rx_valid,
    input logic          wake_brk,
    input logic          fast_chk,
    input logic          dreg_rd,
    input logic          clr_wr,
    input logic [2:0]    clr_data,
    input logic [2:0]    irq_en,
    input logic          pberr,
    input logic          berr,
    input logic          rxrdy,
    input logic          blocked,
    input logic          irq
);
    // R2
    pb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pberr) |-> $past(frame_act && smp_en && !rx_line));

    // R6
    be_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr) |-> $past((tx_done && !fast_chk && (tx_byte != rx_byte))
                              || (rx_valid && !frame_act && !wake_brk)));

    // R8
    blk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked) |-> (rxrdy && berr));

    // R9
    blk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blocked) |-> $past(dreg_rd));

    // R10
    pb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pberr) |-> $past(clr_wr && clr_data[0]));

    // R10
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxrdy) |-> $past(clr_wr && clr_data[2]));

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 3'b000) |-> !irq);
endmodule

bind lin_err_monitor lin_err_monitor_chk #(.DW(DW)) u_err_chk (.*);

// File: tb/lin_err_monitor_tb.sv
module lin_err_monitor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic       rx_line = 1'b1;
    logic       frame_act = 1'b0;
    logic       tx_done = 1'b0;
    logic [7:0] tx_byte = '0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic       wake_brk = 1'b0;
    logic       fast_chk = 1'b0;
    logic       dreg_rd = 1'b0;
    logic       clr_wr = 1'b0;
    logic [2:0] clr_data = '0;
    logic [2:0] irq_en = '0;
    logic       pberr, berr, rxrdy, blocked, irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lin_err_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rx_line(rx_line),
        .frame_act(frame_act), .tx_done(tx_done), .tx_byte(tx_byte),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .wake_brk(wake_brk),
        .fast_chk(fast_chk), .dreg_rd(dreg_rd), .clr_wr(clr_wr),
        .clr_data(clr_data), .irq_en(irq_en), .pberr(pberr), .berr(berr),
        .rxrdy(rxrdy), .blocked(blocked), .irq(irq)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic samples(int n, logic v);
        for (int i = 0; i < n; i++) begin
            rx_line = v;
            smp_en  = 1'b1;
            @(negedge clk);
        end
        smp_en  = 1'b0;
        rx_line = 1'b1;
    endtask

    task automatic clear(logic [2:0] m);
        clr_data = m;
        clr_wr   = 1'b1;
        @(negedge clk);
        clr_wr   = 1'b0;
        clr_data = '0;
    endtask

    task automatic readback(logic [7:0] t, logic [7:0] r);
        tx_byte = t;
        rx_byte = r;
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic rx_strobe(logic [7:0] r);
        rx_byte  = r;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "pberr", pberr, 1'b0);
        chk("R1", "berr", berr, 1'b0);
        chk("R1", "rxrdy", rxrdy, 1'b0);
        chk("R1", "blocked", blocked, 1'b0);
        chk("R1", "irq", irq, 1'b0);
    endtask

    task automatic t_pb_basic();
        frame_act = 1'b1;
        samples(30, 1'b0);
        chk("R2", "pberr after 30 lows", pberr, 1'b0);
        samples(1, 1'b0);
        chk("R2", "pberr after 31 lows", pberr, 1'b1);
        clear(3'b001);
        chk("R10", "pberr cleared", pberr, 1'b0);
        samples(5, 1'b0);
        chk("R5", "no re-set while still low", pberr, 1'b0);
        samples(1, 1'b1);
        samples(31, 1'b0);
        chk("R5", "re-armed after high", pberr, 1'b1);
        clear(3'b001);
        samples(1, 1'b1);
    endtask

    task automatic t_pb_restart();
        samples(30, 1'b0);
        samples(1, 1'b1);
        samples(30, 1'b0);
        chk("R3", "high sample restarts count", pberr, 1'b0);
        samples(1, 1'b1);
    endtask

    task automatic t_pb_gating();
        rx_line = 1'b0;
        smp_en  = 1'b0;
        repeat (40) @(negedge clk);
        chk("R2", "no count without smp_en", pberr, 1'b0);
        rx_line = 1'b1;
        frame_act = 1'b0;
        samples(40, 1'b0);
        chk("R4", "no count outside frame", pberr, 1'b0);
        frame_act = 1'b1;
        samples(20, 1'b0);
        frame_act = 1'b0;
        @(negedge clk);
        frame_act = 1'b1;
        samples(20, 1'b0);
        chk("R4", "frame_act low restarts count", pberr, 1'b0);
        samples(1, 1'b1);
    endtask

    task automatic t_readback();
        fast_chk = 1'b0;
        readback(8'h55, 8'h55);
        chk("R6", "match leaves berr", berr, 1'b0);
        readback(8'h55, 8'h54);
        chk("R6", "mismatch sets berr", berr, 1'b1);
        clear(3'b010);
        chk("R10", "berr cleared", berr, 1'b0);
        fast_chk = 1'b1;
        readback(8'hA0, 8'h0A);
        chk("R7", "fast mode suppresses check", berr, 1'b0);
        fast_chk = 1'b0;
    endtask

    task automatic t_unreq();
        frame_act = 1'b1;
        rx_strobe(8'h33);
        chk("R8", "in-frame byte berr", berr, 1'b0);
        chk("R8", "in-frame byte rxrdy", rxrdy, 1'b0);
        frame_act = 1'b0;
        wake_brk  = 1'b1;
        rx_strobe(8'h00);
        wake_brk  = 1'b0;
        chk("R8", "wake byte blocked", blocked, 1'b0);
        chk("R8", "wake byte berr", berr, 1'b0);
        rx_strobe(8'h12);
        chk("R8", "unrequested berr", berr, 1'b1);
        chk("R8", "unrequested rxrdy", rxrdy, 1'b1);
        chk("R8", "unrequested blocked", blocked, 1'b1);
        clear(3'b111);
        chk("R10", "rxrdy cleared", rxrdy, 1'b0);
        chk("R9", "clear write keeps blocked", blocked, 1'b1);
        dreg_rd = 1'b1;
        @(negedge clk);
        dreg_rd = 1'b0;
        chk("R9", "read releases blocked", blocked, 1'b0);
        frame_act = 1'b1;
    endtask

    task automatic t_w1c_irq();
        readback(8'hFF, 8'h7F);
        clear(3'b101);
        chk("R10", "zero mask bit keeps berr", berr, 1'b1);
        tx_byte  = 8'h01;
        rx_byte  = 8'h02;
        tx_done  = 1'b1;
        clr_data = 3'b010;
        clr_wr   = 1'b1;
        @(negedge clk);
        tx_done  = 1'b0;
        clr_wr   = 1'b0;
        clr_data = '0;
        chk("R10", "set wins over clear", berr, 1'b1);
        irq_en = 3'b000;
        #1;
        chk("R11", "irq masked", irq, 1'b0);
        irq_en = 3'b010;
        #1;
        chk("R11", "irq enabled berr", irq, 1'b1);
        irq_en = 3'b101;
        #1;
        chk("R11", "irq other enables", irq, 1'b0);
        clear(3'b010);
        irq_en = 3'b111;
        #1;
        chk("R11", "irq low with no flags", irq, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pb_basic();
        t_pb_restart();
        t_pb_gating();
        t_readback();
        t_unreq();
        t_w1c_irq();
        finish_run();
    end
endmodule